// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-clock synchronous static memory of 32-bit words that accepts a new read or write command on every rising edge. Reads and writes can follow each other in any order with no idle cycle between them. Read data is flow-through: it comes straight from the storage array, through a bypass merge, in the cycle after the command edge. There is no output register. Write data follows its command by one clock. The array is updated one edge after that, from a one-entry pending-write buffer. A read that arrives right behind a write to the same word still sees the new bytes through the bypass.

A command is either a load or an advance. A load takes a fresh address, a read/write flag and four byte enables, but only when all three chip enables are asserted. An advance steps an internal 2-bit beat counter that replaces the two low address bits. It reuses the direction and byte enables of the last load. The counter follows a linear or an interleaved order, picked by a mode pin. The output enable gates the read bus without waiting for a clock edge. A sleep input freezes the command path and keeps every stored word and the burst position.

Top module: `zbt_flow_sram`

## Requirements
- R1: While and after `rstN` is low, with no accepted read, `rdValid` is 0 and `rdData` is 0.
- R2: All command inputs are sampled only on the rising edge of `clk`. A read load accepted at an edge drives the addressed word on `rdData`, with `rdValid` high, during the following cycle, provided `outEnN` is low.
- R3: Write data for a command accepted at edge k is taken from `wrData` at edge k+1. Byte lane b (bits 8b+7..8b) is written only when `byteWeN[b]` was 0 in the command. Lanes whose bit is 1 keep their old contents.
- R4: Reads and writes mix back to back with no dead cycle. A read issued the cycle after a write to the same address returns the newly written bytes merged with the untouched old bytes.
- R5: A load is accepted only when `ce1N`=0, `ce2`=1 and `ce3N`=0. Otherwise the cycle is a deselect: no read data is driven and no word is written.
- R6: With `burstMode`=0, beat n of a burst (n = advances since the load, modulo 4) accesses low address bits (start + n) mod 4. The upper address bits stay those of the load.
- R7: With `burstMode`=1, beat n accesses low address bits start XOR n.
- R8: An advance reuses the direction and byte enables of the last accepted load. An advance after a deselect, or after reset, is not an access.
- R9: `outEnN`=1 forces `rdValid` to 0 and `rdData` to 0 at once, without waiting for a clock edge. Lowering it mid-cycle presents the pending read data at once.
- R10: While `sleep` is 1 at an edge, the command is ignored. While `sleep` is 1, the read outputs are not valid. Stored words and the burst position are kept, so an advance at the first edge after `sleep` falls continues the interrupted burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| addrIn | input | ADDR_W | Word address for a load |
| advance | input | 1 | 1 = advance the burst, 0 = load a new command |
| writeN | input | 1 | Load direction: 0 = write, 1 = read |
| byteWeN | input | LANES | Active-low byte-lane write enables for a load |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| burstMode | input | 1 | 0 = linear order, 1 = interleaved order |
| outEnN | input | 1 | Asynchronous read output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| wrData | input | DATA_W | Write data, one clock after its command |
| rdData | output | DATA_W | Read data, 0 when not valid |
| rdValid | output | 1 | Read data driven (stands in for the bus leaving high impedance) |

## Verification
A read accepted at edge k is due in the cycle between edges k and k+1. A write's data is sampled at edge k+1 and must be visible to a read accepted at that same edge. The effects of the output enable and of sleep on the read outputs are due within the same cycle, with no edge in between. The bench drives every input at the falling edge, lets the model advance at each rising edge, and compares `rdValid` and `rdData` 2 ns after that edge. It applies data from the previous command to its reference memory at the same edge. For the output-enable case it toggles `outEnN` mid-cycle and samples 1 ns and 0.5 ns later, well before the next edge.

// File: rtl/zbt_sram_pkg.sv
`timescale 1ns/1ps
package zbt_sram_pkg;

  // Strobes handed from the command control to the datapath each cycle.
  typedef struct packed {
    logic accValid;   // an access is in flight this cycle
    logic accWrite;   // 1 = write access, 0 = read access
  } accStrobe_t;

  typedef enum logic {
    BURST_LINEAR     = 1'b0,
    BURST_INTERLEAVE = 1'b1
  } burstOrder_e;

  localparam int BEAT_W = 2;  // beats per burst = 2**BEAT_W

endpackage

// File: rtl/zbt_burst_order.sv
`timescale 1ns/1ps
module zbt_burst_order
  import zbt_sram_pkg::*;
#(
  parameter int CNT_W = BEAT_W
) (
  input  logic [CNT_W-1:0] startLow,
  input  logic [CNT_W-1:0] beatNum,
  input  burstOrder_e      order,
  output logic [CNT_W-1:0] beatLow
);

  always_comb begin
    unique case (order)
      BURST_INTERLEAVE: beatLow = startLow ^ beatNum;
      default:          beatLow = startLow + beatNum;
    endcase
  end

endmodule

// File: rtl/zbt_cmd_ctrl.sv
`timescale 1ns/1ps
module zbt_cmd_ctrl
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advance,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteWeN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              burstMode,
  input  logic              sleep,
  output accStrobe_t        strb,
  output logic [ADDR_W-1:0] accAddr,
  output logic [LANES-1:0]  accBe
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic              chipSel;
  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] nextCnt;
  logic [BEAT_W-1:0] nextLow;
  logic              burstLive;
  logic              curWrite;
  logic [LANES-1:0]  curBe;
  logic              stValid;
  logic [ADDR_W-1:0] stAddr;

  assign chipSel = !ce1N && ce2 && !ce3N;
  assign nextCnt = beatCnt + BEAT_W'(1);

  zbt_burst_order #(.CNT_W(BEAT_W)) u_order (
    .startLow (baseAddr[BEAT_W-1:0]),
    .beatNum  (nextCnt),
    .order    (burstOrder_e'(burstMode)),
    .beatLow  (nextLow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr  <= '0;
      beatCnt   <= '0;
      burstLive <= 1'b0;
      curWrite  <= 1'b0;
      curBe     <= '0;
      stValid   <= 1'b0;
      stAddr    <= '0;
    end else if (sleep) begin
      stValid <= 1'b0;                 // command ignored, burst state kept
    end else if (!advance) begin
      if (chipSel) begin
        baseAddr  <= addrIn;
        beatCnt   <= '0;
        burstLive <= 1'b1;
        curWrite  <= !writeN;
        curBe     <= ~byteWeN;
        stValid   <= 1'b1;
        stAddr    <= addrIn;
      end else begin
        burstLive <= 1'b0;
        stValid   <= 1'b0;
      end
    end else if (burstLive) begin
      beatCnt <= nextCnt;
      stValid <= 1'b1;
      stAddr  <= {baseAddr[ADDR_W-1 -: HI_W], nextLow};
    end else begin
      stValid <= 1'b0;
    end
  end

  assign strb.accValid = stValid;
  assign strb.accWrite = curWrite;
  assign accAddr       = stAddr;
  assign accBe         = curBe;

endmodule

// File: rtl/zbt_data_path.sv
`timescale 1ns/1ps
module zbt_data_path
  import zbt_sram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        strb,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [LANES-1:0]  accBe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEnN,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  // One-entry late-write buffer: data arrives one edge after its command
  // and is committed to the array one edge later still.
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [LANES-1:0]  pendBe;
  logic [DATA_W-1:0] pendData;
  logic [DATA_W-1:0] mergedData;
  logic              addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendBe    <= '0;
      pendData  <= '0;
    end else begin
      pendValid <= strb.accValid && strb.accWrite;
      pendAddr  <= accAddr;
      pendBe    <= accBe;
      pendData  <= wrData;
    end
  end

  assign addrHit = pendValid && (pendAddr == accAddr);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (pendValid && pendBe[g]) laneMem[pendAddr] <= pendData[g*8 +: 8];
    end

    assign mergedData[g*8 +: 8] = (addrHit && pendBe[g]) ? pendData[g*8 +: 8]
                                                         : laneMem[accAddr];
  end

  assign rdValid = strb.accValid && !strb.accWrite && !outEnN && !sleep;
  assign rdData  = rdValid ? mergedData : '0;

endmodule

// File: rtl/zbt_flow_sram.sv
`timescale 1ns/1ps
module zbt_flow_sram
  import zbt_sram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              advance,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteWeN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              burstMode,
  input  logic              outEnN,
  input  logic              sleep,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  accStrobe_t        strb;
  logic [ADDR_W-1:0] accAddr;
  logic [LANES-1:0]  accBe;

  zbt_cmd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrIn    (addrIn),
    .advance   (advance),
    .writeN    (writeN),
    .byteWeN   (byteWeN),
    .ce1N      (ce1N),
    .ce2       (ce2),
    .ce3N      (ce3N),
    .burstMode (burstMode),
    .sleep     (sleep),
    .strb      (strb),
    .accAddr   (accAddr),
    .accBe     (accBe)
  );

  zbt_data_path #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .accAddr (accAddr),
    .accBe   (accBe),
    .wrData  (wrData),
    .outEnN  (outEnN),
    .sleep   (sleep),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/zbt_flow_sram_chk.sv
`timescale 1ns/1ps
module zbt_flow_sram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              advance,
  input logic              writeN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              outEnN,
  input logic              sleep,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid
);

  logic selNow;
  assign selNow = !ce1N && ce2 && !ce3N;

  // R9: a disabled output shows neither valid nor data
  assert_oe_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (!rdValid && rdData == '0));

  // R10: no read is presented while asleep
  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !rdValid);

  // R10: a command offered while asleep is not accepted
  assert_sleep_ignores_R10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !rdValid);

  // R5: a load without all chip enables is a deselect
  assert_deselect_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !advance && !selNow) |=> !rdValid);

  // R2: an accepted read load presents data in the very next cycle
  assert_read_flow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !advance && selNow && writeN) |=> (rdValid || outEnN || sleep));

  // R8: advancing after a deselect is not an access
  assert_adv_dead_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && advance && $past(!sleep && !advance && !selNow)) |=> !rdValid);

endmodule

bind zbt_flow_sram zbt_flow_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .advance (advance),
  .writeN  (writeN),
  .ce1N    (ce1N),
  .ce2     (ce2),
  .ce3N    (ce3N),
  .outEnN  (outEnN),
  .sleep   (sleep),
  .rdData  (rdData),
  .rdValid (rdValid)
);

// File: tb/test_zbt_flow_sram.sv
`timescale 1ns/1ps
module test_zbt_flow_sram;

  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic        advance = 1'b0;
  logic        writeN = 1'b1;
  logic [3:0]  byteWeN = 4'hF;
  logic        ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic        burstMode = 1'b0;
  logic        outEnN = 1'b0;
  logic        sleep = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;

  always #4 clk = ~clk;   // 125 MHz

  zbt_flow_sram #(.DEPTH(DEPTH), .DATA_W(32)) i_zbt_flow_sram (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .advance(advance),
    .writeN(writeN), .byteWeN(byteWeN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .burstMode(burstMode), .outEnN(outEnN), .sleep(sleep), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] refMem [DEPTH];
  logic [2:0]  gCe = 3'b010;    // {ce1N, ce2, ce3N}; 010 = selected
  logic        gMode = 0, gOeN = 0, gSleep = 0;
  logic [31:0] carryData = '0;
  logic        mValid = 0, mWrite = 0, mLive = 0;
  logic [3:0]  mBe = '0;
  logic [AW-1:0] mBase = '0, mAddr = '0;
  logic [1:0]  mCnt = '0;

  function automatic logic [31:0] pat(input int a, input int salt);
    return (32'h9E3779B9 * (a + 1)) ^ (a << 20) ^ (salt * 32'h01030507);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic adv, input logic wrN, input logic [AW-1:0] addr,
                      input logic [3:0] beN, input logic [31:0] newData, input string tag);
    logic expV;
    @(negedge clk);
    advance = adv; writeN = wrN; addrIn = addr; byteWeN = beN;
    {ce1N, ce2, ce3N} = gCe; burstMode = gMode; outEnN = gOeN; sleep = gSleep;
    wrData = carryData;
    carryData = newData;
    @(posedge clk);
    // data phase of the command accepted one edge earlier (R3)
    if (mValid && mWrite)
      for (int l = 0; l < 4; l++)
        if (mBe[l]) refMem[mAddr][l*8 +: 8] = wrData[l*8 +: 8];
    // command phase
    if (gSleep) mValid = 0;
    else if (!adv) begin
      if (gCe == 3'b010) begin
        mBase = addr; mCnt = 0; mLive = 1; mWrite = !wrN; mBe = ~beN;
        mValid = 1; mAddr = addr;
      end else begin
        mLive = 0; mValid = 0;
      end
    end else if (mLive) begin
      mCnt = mCnt + 1; mValid = 1;
      mAddr = {mBase[AW-1:2], gMode ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt)};
    end else mValid = 0;
    #2;
    expV = mValid && !mWrite && !gOeN && !gSleep;
    chk({tag, " valid"}, {31'd0, rdValid}, {31'd0, expV});
    chk({tag, " data"}, rdData, expV ? refMem[mAddr] : 32'd0);
  endtask

  task automatic ldWr(input int a, input logic [3:0] beN, input logic [31:0] d, input string tag);
    step(1'b0, 1'b0, AW'(a), beN, d, tag);
  endtask
  task automatic ldRd(input int a, input string tag);
    step(1'b0, 1'b1, AW'(a), 4'hF, 32'd0, tag);
  endtask
  task automatic adv(input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, '0, 4'hF, d, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset valid", {31'd0, rdValid}, 32'd0);
    chk("R1 reset data", rdData, 32'd0);
    @(negedge clk); rstN = 1'b1;
    adv(32'd0, "R8 advance after reset");

    // R3: fill every word with full-lane writes, back to back
    for (int a = 0; a < DEPTH; a++) ldWr(a, 4'h0, pat(a, 0), "R3 fill");
    // R2: read every word back to back right after the last write
    for (int a = 0; a < DEPTH; a++) ldRd(a, "R2 sweep read");

    // R3 R4: every byte-enable pattern, read of same word right after write
    for (int be = 0; be < 16; be++) begin
      ldWr(be, 4'(be), pat(be, 7), "R3 lane write");
      ldRd(be, "R4 bypass read");
    end
    // R4: write, write, read mix on adjacent words
    for (int a = 16; a < 24; a++) begin
      ldWr(a, 4'h0, pat(a, 3), "R4 mix write");
      ldWr(a + 1, 4'b1010, pat(a, 4), "R4 mix write2");
      ldRd(a, "R4 mix read");
      ldRd(a + 1, "R4 mix read2");
    end

    // R6 R7: read bursts from every start, both orders
    for (int m = 0; m < 2; m++) begin
      gMode = 1'(m);
      for (int s = 0; s < 4; s++) begin
        ldRd(32 + s, m ? "R7 burst load" : "R6 burst load");
        for (int b = 0; b < 5; b++) adv(32'd0, m ? "R7 interleave beat" : "R6 linear beat");
      end
    end

    // R8: write burst carries direction and byte enables
    gMode = 1'b1;
    ldWr(46, 4'b0101, pat(46, 9), "R8 burst write load");
    for (int b = 1; b < 4; b++) adv(pat(46, 9 + b), "R8 burst write beat");
    gMode = 1'b0;
    ldRd(44, "R8 readback");
    for (int b = 1; b < 4; b++) adv(32'd0, "R8 readback beat");

    // R5: each chip enable alone deselects
    for (int c = 0; c < 3; c++) begin
      gCe = 3'b010 ^ (3'b100 >> c);
      ldRd(5, "R5 deselect read");
      adv(32'd0, "R8 advance after deselect");
      ldWr(6, 4'h0, 32'hDEAD0000 | c, "R5 deselect write");
      adv(32'hBEEF0000 | c, "R5 deselect data");
      gCe = 3'b010;
      ldRd(6, "R5 word unchanged");
    end

    // R9: output enable is asynchronous
    gOeN = 1'b1;
    ldRd(7, "R9 disabled read");
    outEnN = 1'b0; #1;
    chk("R9 async enable valid", {31'd0, rdValid}, 32'd1);
    chk("R9 async enable data", rdData, refMem[7]);
    outEnN = 1'b1; #0.5;
    chk("R9 async disable valid", {31'd0, rdValid}, 32'd0);
    chk("R9 async disable data", rdData, 32'd0);
    gOeN = 1'b0;

    // R10: sleep holds everything, burst resumes after wake
    gMode = 1'b0;
    ldRd(41, "R10 burst start");
    adv(32'd0, "R10 beat before sleep");
    gSleep = 1'b1;
    adv(32'd0, "R10 asleep advance");
    ldWr(41, 4'h0, 32'h5A5A5A5A, "R10 asleep write");
    adv(32'h12345678, "R10 asleep data");
    gSleep = 1'b0;
    adv(32'd0, "R10 resumed beat");
    adv(32'd0, "R10 resumed beat2");
    ldRd(41, "R10 contents kept");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule